// File: doc/BRIEF.md
# Sampled Page Working-Set Tracker

This block keeps a running estimate of which pages in a fixed group are in active use. Each page has an access strobe. A pulse on the strobe sets that page's live "touched" bit. A free-running interval timer fires once every `TICK_PERIOD` clock edges. On each firing, every page's touched bit moves into the low end of a per-page history shift register, and the touched bit is cleared for the next interval. The oldest sample falls out of the top of the register. The result is a sliding window of about `HIST_DEPTH` intervals, built from coarse samples rather than from a record of every reference.

A page is counted as resident in the working set if its live bit is set or if any of its history bits is set. The block drives this membership as a vector, one bit per page. It also drives a registered count of the member pages. That count is compared with a frame budget supplied on an input, and a demand flag rises when the set needs more frames than the budget allows. A scheduler or memory manager reads these outputs to decide how to react.

Top module: `wsTracker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the outputs are all zero: `memberVec`, `memberCount` and `overDemand`. Reset also clears the timer.
- R2: An access strobe on page i at a clock edge sets `memberVec[i]` right after that edge.
- R3: The interval timer fires on edges TICK_PERIOD, 2·TICK_PERIOD, and so on, counted from the first edge after reset. On a firing edge, each page's touched bit enters history bit 0 and every other history bit moves up by one.
- R4: A page that is not accessed again stays a member through HIST_DEPTH firings. It leaves the set on the (HIST_DEPTH+1)-th firing edge that comes after its last access.
- R5: An access in the same cycle as a firing is stored in the freshly cleared touched bit and is not lost. The page then stays a member until the (HIST_DEPTH+1)-th firing that follows.
- R6: `memberCount` holds the number of ones that `memberVec` had in the previous cycle, so it lags membership by one edge. It never exceeds NUM_PAGES.
- R7: `overDemand` is registered together with `memberCount`. After each edge it is 1 exactly when the new `memberCount` is greater than the `frameLimit` value present at that edge (unsigned compare).
- R8: Pages are independent. An access to one page changes neither the membership nor the aging of any other page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| accessStrobe | input | NUM_PAGES | One pulse per page reference, bit i is page i |
| frameLimit | input | CNT_W | Frame budget compared with the member count |
| memberVec | output | NUM_PAGES | Working-set membership, bit i is page i |
| memberCount | output | CNT_W | Registered population count of the set |
| overDemand | output | 1 | Set when the member count exceeds the frame budget |

## Verification
Membership is due one edge after the access or firing that changes it. The count and the demand flag are due one edge after that, because they are computed from the membership the previous cycle had. The bench numbers every edge from reset release. For each edge it derives the interval index from the edge number. It then pushes onto the scoreboard what membership, count and flag must be right after that edge. The monitor compares each entry a quarter period after its edge, well clear of both clock transitions. Firing edges are found from the edge number alone, so accesses placed exactly on a firing edge and on the boundary where a page ages out are checked at the cycle where the change must appear.

// File: rtl/wsPkg.sv
package wsPkg;
  // Strobes sent from the interval control to the page datapath
  typedef struct packed {
    logic sampleHist;  // shift touched bits into history
    logic clearRef;    // restart touched bits for the new interval
  } wsStrobe_t;
endpackage

// File: rtl/wsTimerCtrl.sv
module wsTimerCtrl
  import wsPkg::*;
#(
  parameter int TICK_PERIOD = 5000
) (
  input  logic      clk,
  input  logic      rstN,
  output wsStrobe_t strobe
);
  localparam int TW = (TICK_PERIOD > 2) ? $clog2(TICK_PERIOD) : 1;
  localparam logic [TW-1:0] LAST_COUNT = TW'(TICK_PERIOD - 1);

  logic [TW-1:0] timerVal;
  logic          tickNow;

  assign tickNow = (timerVal == LAST_COUNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerVal <= '0;
    end else if (tickNow) begin
      timerVal <= '0;
    end else begin
      timerVal <= timerVal + 1'b1;
    end
  end

  always_comb begin
    strobe.sampleHist = tickNow;
    strobe.clearRef   = tickNow;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    timerVal <= LAST_COUNT);  // R3
  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleHist |=> (timerVal == '0));  // R3
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sampleHist |=> (timerVal == $past(timerVal) + 1'b1));  // R3
endmodule

// File: rtl/wsPageDatapath.sv
module wsPageDatapath
  import wsPkg::*;
#(
  parameter int NUM_PAGES  = 8,
  parameter int HIST_DEPTH = 2,
  parameter int CNT_W      = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wsStrobe_t            strobe,
  input  logic [NUM_PAGES-1:0] accessStrobe,
  input  logic [CNT_W-1:0]     frameLimit,
  output logic [NUM_PAGES-1:0] memberVec,
  output logic [CNT_W-1:0]     memberCount,
  output logic                 overDemand
);
  logic [NUM_PAGES-1:0]  refBit;
  logic [HIST_DEPTH-1:0] histReg [NUM_PAGES];
  logic [CNT_W-1:0]      popNow;

  function automatic logic [CNT_W-1:0] popCount(input logic [NUM_PAGES-1:0] v);
    logic [CNT_W-1:0] sum;
    sum = '0;
    for (int j = 0; j < NUM_PAGES; j++) begin
      sum = sum + CNT_W'(v[j]);
    end
    return sum;
  endfunction

  for (genvar i = 0; i < NUM_PAGES; i++) begin : gPage
    logic [HIST_DEPTH-1:0] histNext;

    if (HIST_DEPTH == 1) begin : gShallow
      assign histNext = refBit[i];
    end else begin : gDeep
      assign histNext = {histReg[i][HIST_DEPTH-2:0], refBit[i]};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        refBit[i]  <= 1'b0;
        histReg[i] <= '0;
      end else begin
        if (strobe.sampleHist) histReg[i] <= histNext;
        if (strobe.clearRef)   refBit[i]  <= accessStrobe[i];
        else                   refBit[i]  <= refBit[i] | accessStrobe[i];
      end
    end

    assign memberVec[i] = refBit[i] | (|histReg[i]);

    AST_HIST_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
      strobe.sampleHist |=> (histReg[i][0] == $past(refBit[i])));  // R3
    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.sampleHist |=> $stable(histReg[i]));  // R4
  end

  assign popNow = popCount(memberVec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memberCount <= '0;
      overDemand  <= 1'b0;
    end else begin
      memberCount <= popNow;
      overDemand  <= (popNow > frameLimit);
    end
  end

  AST_FRESH_REF: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearRef |=> (refBit == $past(accessStrobe)));  // R5
  AST_ACCESS_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    (accessStrobe != '0) |=> ((memberVec & $past(accessStrobe)) == $past(accessStrobe)));  // R2
  AST_COUNT_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (32'(memberCount) == $countones($past(memberVec))));  // R6
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    32'(memberCount) <= NUM_PAGES);  // R6
  AST_OVER_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (overDemand == (memberCount > $past(frameLimit))));  // R7
endmodule

// File: rtl/wsTracker.sv
module wsTracker
  import wsPkg::*;
#(
  parameter int NUM_PAGES   = 8,
  parameter int HIST_DEPTH  = 2,
  parameter int TICK_PERIOD = 5000,
  localparam int CNT_W      = $clog2(NUM_PAGES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PAGES-1:0] accessStrobe,
  input  logic [CNT_W-1:0]     frameLimit,
  output logic [NUM_PAGES-1:0] memberVec,
  output logic [CNT_W-1:0]     memberCount,
  output logic                 overDemand
);
  wsStrobe_t strobe;

  wsTimerCtrl #(
    .TICK_PERIOD(TICK_PERIOD)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe)
  );

  wsPageDatapath #(
    .NUM_PAGES (NUM_PAGES),
    .HIST_DEPTH(HIST_DEPTH),
    .CNT_W     (CNT_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .accessStrobe(accessStrobe),
    .frameLimit  (frameLimit),
    .memberVec   (memberVec),
    .memberCount (memberCount),
    .overDemand  (overDemand)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (memberVec == '0 && memberCount == '0 && !overDemand));  // R1
endmodule

// File: tb/tb_wsTracker.sv
module tb_wsTracker;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int HD = 2;
  localparam int TP = 8;
  localparam int CW = $clog2(NP + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] accessStrobe = '0;
  logic [CW-1:0] frameLimit = '0;
  logic [NP-1:0] memberVec;
  logic [CW-1:0] memberCount;
  logic          overDemand;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [NP-1:0] vec;
    int            cnt;
    bit            over;
    string         tag;
  } item_t;
  item_t sb[$];

  int edgeNum = 0;
  int lastIdx [NP];
  logic [NP-1:0] prevVec = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsTracker #(.NUM_PAGES(NP), .HIST_DEPTH(HD), .TICK_PERIOD(TP)) dut (
    .clk(clk), .rstN(rstN), .accessStrobe(accessStrobe), .frameLimit(frameLimit),
    .memberVec(memberVec), .memberCount(memberCount), .overDemand(overDemand));

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: called at a falling edge; drives one cycle and predicts the next edge
  task automatic step(input logic [NP-1:0] acc, input int lim, input string tag);
    item_t it;
    int idx;
    int ones;
    accessStrobe = acc;
    frameLimit   = CW'(lim);
    edgeNum++;
    idx = edgeNum / TP;  // firing edges are multiples of TP (R3)
    ones = 0;
    for (int i = 0; i < NP; i++) begin
      if (acc[i]) lastIdx[i] = idx;
      it.vec[i] = (lastIdx[i] >= idx - HD);
      ones += int'(prevVec[i]);
    end
    it.cnt  = ones;
    it.over = (ones > lim);
    it.tag  = tag;
    prevVec = it.vec;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input int lim, input string tag);
    for (int c = 0; c < n; c++) step('0, lim, tag);
  endtask

  // Monitor: compares each prediction a quarter period after its edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(memberVec === it.vec, it.tag, "memberVec", int'(memberVec), int'(it.vec));
        check(int'(memberCount) == it.cnt && !$isunknown(memberCount), "R6", "memberCount",
              int'(memberCount), it.cnt);
        check(overDemand === it.over, "R7", "overDemand", int'(overDemand), int'(it.over));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) lastIdx[i] = -100;
    repeat (3) @(negedge clk);
    check(memberVec == '0, "R1", "memberVec in reset", int'(memberVec), 0);
    check(memberCount == '0, "R1", "memberCount in reset", int'(memberCount), 0);
    check(overDemand == 1'b0, "R1", "overDemand in reset", int'(overDemand), 0);
    rstN = 1'b1;

    idle(3, 8, "R1");
    step(8'h01, 8, "R2");        // edge 4: page 0 touched
    idle(22, 8, "R4");           // ages out at edge 24 (third firing)
    step(8'h04, 8, "R8");        // edge 27: page 2, page 0 unaffected
    idle(4, 8, "R8");
    step(8'h08, 8, "R5");        // edge 32: access on a firing edge
    idle(26, 8, "R5");           // page 3 lasts until edge 56
    step(8'h02, 8, "R3");        // edge 59: page 1 just before firing edge 64
    idle(6, 8, "R3");
    step(8'hFF, 5, "R7");
    for (int l = 0; l < 9; l++) step(8'h00, l, "R7");
    step(8'h0F, 3, "R7");
    idle(4, 4, "R7");
    idle(30, 0, "R4");
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule